// File: doc/BRIEF.md
# Interrupt Entry and Vector Fetch Sequencer

This block sits between the interrupt sources of a small processor and its core. When a maskable request arrives while the enable flag is set, or a non-maskable request arrives, or the core raises a software request with its own vector number, the block runs the entry sequence on its own. It saves the return state on a memory stack, clears the enable flag and works out an 8-bit vector number. For a maskable request it obtains that number through an acknowledge handshake. It then fetches the handler address from a vector table at address zero and hands the core a segment:offset jump target together with the new stack pointer.

The table holds 256 entries of four bytes each. For vector v, the offset halfword is at byte address 4v and the segment halfword is at 4v+2. A return command walks the stack in the opposite direction. It restores the saved flags, including the enable bit, and hands back the interrupted segment and offset. Memory is reached through a simple request/grant port. A read completes in the cycle its grant is seen, with the data valid in that cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the enable flag (`ie_flag`) is 0, `busy`, `jmp_vld`, `rsm_vld`, `ack_req` and `mem_req` are 0.
- R2: While idle, `flag_clr` clears and `flag_set` sets the enable flag, with clear winning if both are high. The new value already governs a maskable request sampled in the same cycle.
- R3: A maskable request (`irq_req`) with the enable flag at 0 starts nothing: no busy, no acknowledge and no memory access.
- R4: A taken maskable request raises `ack_req` and waits for `ack_valid`. The vector is `ack_vec` as sampled with `ack_valid`. Acknowledge and memory requests are never active together.
- R5: Entry pushes three halfwords, flags first, then segment, then offset. The stack pointer drops by 2 before each write, so the writes go to `sp_in`-2, -4 and -6. The pushed flags word is `cur_flags` with bit 9 replaced by the enable flag as it stood when the request was taken. `tgt_sp` ends at `sp_in`-6.
- R6: The offset is read at 4v and the segment at 4v+2, each as one halfword read. `jmp_vld` then pulses for exactly one cycle with `tgt_off` and `tgt_seg` holding those values.
- R7: The enable flag is 0 from the cycle after entry starts. `tgt_flags` at the jump is the pushed flags word with bit 9 cleared.
- R8: A non-maskable request (`nmi_req`) is taken even with the enable flag at 0. It uses vector 2 and no acknowledge cycle.
- R9: When several requests are sampled together, the non-maskable one wins over the software one, which wins over the maskable one.
- R10: A software request (`sw_req`) uses `sw_vec` as its vector, takes no acknowledge cycle and reads the table at the same addresses as a hardware request.
- R11: `busy` is high from the cycle after detection until the cycle in which `jmp_vld` pulses. Requests and flag commands seen while busy are dropped.
- R12: A return command (`ret_req`, while idle with no request) reads the offset at `sp_in`, the segment at `sp_in`+2 and the flags at `sp_in`+4. It restores the enable flag from flags bit 9, then pulses `rsm_vld` with those values and `tgt_sp` = `sp_in`+6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Maskable request |
| nmi_req | input | 1 | Non-maskable request |
| sw_req | input | 1 | Software request |
| sw_vec | input | 8 | Vector carried by the software request |
| ret_req | input | 1 | Return-from-handler command |
| flag_set | input | 1 | Set the enable flag |
| flag_clr | input | 1 | Clear the enable flag |
| cur_seg | input | 16 | Segment of the interrupted code |
| cur_off | input | 16 | Offset of the interrupted code |
| cur_flags | input | 16 | Flags word of the core (bit 9 is replaced) |
| sp_in | input | 16 | Stack pointer captured at entry or return |
| ack_req | output | 1 | Acknowledge request for a maskable interrupt |
| ack_valid | input | 1 | Acknowledge answer valid |
| ack_vec | input | 8 | Vector returned by the acknowledge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Byte address of the halfword |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_rdata | input | 16 | Read data, valid with grant |
| busy | output | 1 | Sequence in progress |
| ie_flag | output | 1 | Current enable flag |
| jmp_vld | output | 1 | One-cycle pulse: handler target valid |
| rsm_vld | output | 1 | One-cycle pulse: resume target valid |
| tgt_seg | output | 16 | Target segment |
| tgt_off | output | 16 | Target offset |
| tgt_flags | output | 16 | Flags for the target |
| tgt_sp | output | 16 | Stack pointer after the sequence |

## Verification
The bench drives a flag command in the same cycle as a maskable request. A design that applied the command one cycle late would take or drop the wrong request. Simultaneous requests are sent in different combinations, where a wrong priority shows up as a wrong vector or a stray acknowledge. The bench also reads the first and last table entries, where a wrong entry scale or wrong halfword order returns another entry's data. Requests raised in the middle of a sequence must not cause a second jump. Every entry is followed by a return, so a design that pushes in the wrong order or restores the enable bit incorrectly hands back a wrong resume target or flag.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE   = 4'd0,
        S_ACK    = 4'd1,
        S_PUSH_F = 4'd2,
        S_PUSH_S = 4'd3,
        S_PUSH_O = 4'd4,
        S_RD_OFF = 4'd5,
        S_RD_SEG = 4'd6,
        S_POP_O  = 4'd7,
        S_POP_S  = 4'd8,
        S_POP_F  = 4'd9
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_SW   = 2'd2,
        SRC_IRQ  = 2'd3
    } seq_src_e;

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
    import irq_seq_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int NMI_VEC = 2
) (
    input  logic             nmi,
    input  logic             sw,
    input  logic [VEC_W-1:0] sw_vec,
    input  logic             irq,
    input  logic             ie_eff,
    input  logic             ret,
    output seq_src_e         src,
    output logic [VEC_W-1:0] vec_sel,
    output logic             ret_go
);

    always_comb begin
        src     = SRC_NONE;
        vec_sel = '0;
        if (nmi) begin
            src     = SRC_NMI;
            vec_sel = VEC_W'(NMI_VEC);
        end else if (sw) begin
            src     = SRC_SW;
            vec_sel = sw_vec;
        end else if (irq && ie_eff) begin
            src     = SRC_IRQ;
        end
        ret_go = ret && (src == SRC_NONE);
    end

endmodule

// File: rtl/irq_seq_agen.sv
module irq_seq_agen #(
    parameter int VEC_W = 8,
    parameter int AW    = 16
) (
    input  logic [VEC_W-1:0] vec,
    input  logic             hi_half,
    input  logic [AW-1:0]    sp,
    output logic [AW-1:0]    tbl_addr,
    output logic [AW-1:0]    push_addr,
    output logic [AW-1:0]    pop_next
);

    localparam int TBL_W = VEC_W + 2;

    logic [TBL_W-1:0] tbl_raw;

    always_comb begin
        tbl_raw   = {vec, hi_half, 1'b0};
        tbl_addr  = AW'(tbl_raw);
        push_addr = sp - AW'(2);
        pop_next  = sp + AW'(2);
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int DW      = 16,
    parameter int AW      = 16,
    parameter int IE_BIT  = 9,
    parameter int NMI_VEC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic             nmi_req,
    input  logic             sw_req,
    input  logic [VEC_W-1:0] sw_vec,
    input  logic             ret_req,
    input  logic             flag_set,
    input  logic             flag_clr,
    input  logic [DW-1:0]    cur_seg,
    input  logic [DW-1:0]    cur_off,
    input  logic [DW-1:0]    cur_flags,
    input  logic [AW-1:0]    sp_in,
    output logic             ack_req,
    input  logic             ack_valid,
    input  logic [VEC_W-1:0] ack_vec,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_gnt,
    input  logic [DW-1:0]    mem_rdata,
    output logic             busy,
    output logic             ie_flag,
    output logic             jmp_vld,
    output logic             rsm_vld,
    output logic [DW-1:0]    tgt_seg,
    output logic [DW-1:0]    tgt_off,
    output logic [DW-1:0]    tgt_flags,
    output logic [AW-1:0]    tgt_sp
);

    typedef struct packed {
        seq_state_e       st;
        logic             ie;
        logic [VEC_W-1:0] vec;
        logic [AW-1:0]    sp;
        logic [DW-1:0]    w_flags;
        logic [DW-1:0]    w_seg;
        logic [DW-1:0]    w_off;
        logic [DW-1:0]    t_seg;
        logic [DW-1:0]    t_off;
        logic [DW-1:0]    t_flags;
        logic             jmp;
        logic             rsm;
    } seq_regs_t;

    seq_regs_t q, d;

    logic             idle;
    logic             ie_eff;
    logic [DW-1:0]    flags_push;
    seq_src_e         src;
    logic [VEC_W-1:0] vec_sel;
    logic             ret_go;
    logic [AW-1:0]    tbl_addr;
    logic [AW-1:0]    push_addr;
    logic [AW-1:0]    pop_next;

    assign idle = (q.st == S_IDLE);

    // Flag commands apply in the sampling cycle, clear wins.
    always_comb begin
        ie_eff = q.ie;
        if (idle) begin
            if (flag_clr)      ie_eff = 1'b0;
            else if (flag_set) ie_eff = 1'b1;
        end
        flags_push         = cur_flags;
        flags_push[IE_BIT] = ie_eff;
    end

    irq_seq_arb #(
        .VEC_W   (VEC_W),
        .NMI_VEC (NMI_VEC)
    ) u_arb (
        .nmi     (nmi_req && idle),
        .sw      (sw_req && idle),
        .sw_vec  (sw_vec),
        .irq     (irq_req && idle),
        .ie_eff  (ie_eff),
        .ret     (ret_req && idle),
        .src     (src),
        .vec_sel (vec_sel),
        .ret_go  (ret_go)
    );

    irq_seq_agen #(
        .VEC_W (VEC_W),
        .AW    (AW)
    ) u_agen (
        .vec       (q.vec),
        .hi_half   (q.st == S_RD_SEG),
        .sp        (q.sp),
        .tbl_addr  (tbl_addr),
        .push_addr (push_addr),
        .pop_next  (pop_next)
    );

    always_comb begin
        d         = q;
        d.jmp     = 1'b0;
        d.rsm     = 1'b0;
        ack_req   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.st)
            S_IDLE: begin
                d.ie = ie_eff;
                if (src != SRC_NONE) begin
                    d.w_flags = flags_push;
                    d.w_seg   = cur_seg;
                    d.w_off   = cur_off;
                    d.sp      = sp_in;
                    d.ie      = 1'b0;
                    d.vec     = vec_sel;
                    d.st      = (src == SRC_IRQ) ? S_ACK : S_PUSH_F;
                end else if (ret_go) begin
                    d.sp = sp_in;
                    d.st = S_POP_O;
                end
            end
            S_ACK: begin
                ack_req = 1'b1;
                if (ack_valid) begin
                    d.vec = ack_vec;
                    d.st  = S_PUSH_F;
                end
            end
            S_PUSH_F, S_PUSH_S, S_PUSH_O: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = push_addr;
                case (q.st)
                    S_PUSH_F: mem_wdata = q.w_flags;
                    S_PUSH_S: mem_wdata = q.w_seg;
                    default:  mem_wdata = q.w_off;
                endcase
                if (mem_gnt) begin
                    d.sp = push_addr;
                    case (q.st)
                        S_PUSH_F: d.st = S_PUSH_S;
                        S_PUSH_S: d.st = S_PUSH_O;
                        default:  d.st = S_RD_OFF;
                    endcase
                end
            end
            S_RD_OFF: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
                if (mem_gnt) begin
                    d.t_off = mem_rdata;
                    d.st    = S_RD_SEG;
                end
            end
            S_RD_SEG: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
                if (mem_gnt) begin
                    d.t_seg           = mem_rdata;
                    d.t_flags         = q.w_flags;
                    d.t_flags[IE_BIT] = 1'b0;
                    d.jmp             = 1'b1;
                    d.st              = S_IDLE;
                end
            end
            S_POP_O, S_POP_S, S_POP_F: begin
                mem_req  = 1'b1;
                mem_addr = q.sp;
                if (mem_gnt) begin
                    d.sp = pop_next;
                    case (q.st)
                        S_POP_O: begin
                            d.t_off = mem_rdata;
                            d.st    = S_POP_S;
                        end
                        S_POP_S: begin
                            d.t_seg = mem_rdata;
                            d.st    = S_POP_F;
                        end
                        default: begin
                            d.t_flags = mem_rdata;
                            d.ie      = mem_rdata[IE_BIT];
                            d.rsm     = 1'b1;
                            d.st      = S_IDLE;
                        end
                    endcase
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = !idle;
    assign ie_flag   = q.ie;
    assign jmp_vld   = q.jmp;
    assign rsm_vld   = q.rsm;
    assign tgt_seg   = q.t_seg;
    assign tgt_off   = q.t_off;
    assign tgt_flags = q.t_flags;
    assign tgt_sp    = q.sp;

    // R7
    ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && src != SRC_NONE) |=> !ie_flag)
        else $error("enable flag not cleared on entry");

    // R8
    nmi_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && nmi_req) |=> (busy && !ack_req))
        else $error("non-maskable request not taken directly");

    // R4
    ack_mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_req && mem_req))
        else $error("acknowledge overlaps memory access");

    // R5
    push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_gnt) |=> (tgt_sp == $past(mem_addr)))
        else $error("stack pointer does not follow push address");

    // R6
    jmp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_vld |=> !jmp_vld)
        else $error("jump valid longer than one cycle");

    // R11
    busy_jmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_vld |-> !busy)
        else $error("busy still high at jump");

    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(jmp_vld && rsm_vld))
        else $error("jump and resume together");

endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0, nmi_req = 1'b0, sw_req = 1'b0, ret_req = 1'b0;
    logic        flag_set = 1'b0, flag_clr = 1'b0;
    logic [7:0]  sw_vec = '0;
    logic [15:0] cur_seg = '0, cur_off = '0, cur_flags = '0, sp_in = '0;
    logic        ack_req, ack_valid;
    logic [7:0]  ack_vec = '0;
    logic        mem_req, mem_we, mem_gnt;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, ie_flag, jmp_vld, rsm_vld;
    logic [15:0] tgt_seg, tgt_off, tgt_flags, tgt_sp;

    int n_tests = 0;
    int n_fail  = 0;
    int wn = 0, n_ack = 0, n_mreq = 0, n_jmp = 0;
    logic [15:0] wlog_a [64];
    logic [15:0] wlog_d [64];
    logic [15:0] stk [64];
    logic [31:0] cyc = '0;

    always #4 clk = ~clk;

    irq_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
        .sw_req(sw_req), .sw_vec(sw_vec), .ret_req(ret_req),
        .flag_set(flag_set), .flag_clr(flag_clr), .cur_seg(cur_seg),
        .cur_off(cur_off), .cur_flags(cur_flags), .sp_in(sp_in),
        .ack_req(ack_req), .ack_valid(ack_valid), .ack_vec(ack_vec),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .busy(busy), .ie_flag(ie_flag), .jmp_vld(jmp_vld), .rsm_vld(rsm_vld),
        .tgt_seg(tgt_seg), .tgt_off(tgt_off), .tgt_flags(tgt_flags),
        .tgt_sp(tgt_sp)
    );

    function automatic logic [15:0] off_of(input logic [7:0] v);
        return {8'h40, v};
    endfunction

    function automatic logic [15:0] seg_of(input logic [7:0] v);
        return {~v, 8'h1C};
    endfunction

    // memory model: table below 0x400, small stack window elsewhere
    assign mem_gnt = mem_req && (cyc[1:0] != 2'b11);
    always_comb begin
        if (mem_addr < 16'h0400)
            mem_rdata = mem_addr[1] ? seg_of(mem_addr[9:2]) : off_of(mem_addr[9:2]);
        else
            mem_rdata = stk[mem_addr[6:1]];
    end

    always_ff @(posedge clk) begin
        cyc <= cyc + 1;
        ack_valid <= rst_n && ack_req && !ack_valid;
        if (ack_valid) n_ack <= n_ack + 1;
        if (mem_req)   n_mreq <= n_mreq + 1;
        if (jmp_vld)   n_jmp <= n_jmp + 1;
        if (mem_req && mem_we && mem_gnt) begin
            stk[mem_addr[6:1]] <= mem_wdata;
            wlog_a[wn % 64]    <= mem_addr;
            wlog_d[wn % 64]    <= mem_wdata;
            wn                 <= wn + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 irq, 1 nmi, 2 sw, 3 nmi+sw+irq, 4 sw+irq
    localparam logic [43:0] VTAB [0:7] = '{
        {3'd0, 1'b1, 8'h09, 16'hFFF0, 16'h1234},
        {3'd1, 1'b0, 8'h00, 16'hFFE0, 16'h0100},
        {3'd2, 1'b0, 8'h80, 16'hFFD0, 16'h2222},
        {3'd2, 1'b1, 8'h10, 16'hFFC0, 16'h0F0F},
        {3'd0, 1'b1, 8'hFF, 16'hFFB0, 16'hABCD},
        {3'd0, 1'b1, 8'h00, 16'hFFA0, 16'h7777},
        {3'd3, 1'b1, 8'h33, 16'hFF90, 16'h4321},
        {3'd4, 1'b1, 8'h44, 16'hFF88, 16'h5555}
    };

    localparam logic [15:0] BASE_FLAGS = 16'h00C3;

    task automatic wait_for(input bit want_jmp, output bit seen);
        seen = 1'b0;
        for (int t = 0; t < 200; t++) begin
            if (want_jmp ? jmp_vld : rsm_vld) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic do_entry(input logic [2:0] kind, input logic ie, input logic [7:0] v,
                            input logic [15:0] sp, input logic [15:0] off,
                            output logic [15:0] pushed);
        logic [15:0] seg;
        logic [7:0]  ev;
        int          wb, ab;
        bit          seen;
        seg    = off ^ 16'h5A5A;
        pushed = ie ? (BASE_FLAGS | 16'h0200) : BASE_FLAGS;
        ev     = (kind == 3'd1 || kind == 3'd3) ? 8'h02 : v;
        @(negedge clk);
        wb = wn;
        ab = n_ack;
        cur_seg = seg; cur_off = off; cur_flags = BASE_FLAGS; sp_in = sp;
        flag_set = ie; flag_clr = !ie;
        ack_vec  = (kind == 3'd0) ? v : ~v;
        sw_vec   = v;
        irq_req  = (kind == 3'd0 || kind == 3'd3 || kind == 3'd4);
        nmi_req  = (kind == 3'd1 || kind == 3'd3);
        sw_req   = (kind == 3'd2 || kind == 3'd3 || kind == 3'd4);
        @(negedge clk);
        {irq_req, nmi_req, sw_req, flag_set, flag_clr} = '0;
        chk("R11 busy after detection", busy, 1'b1);
        chk("R7 enable cleared on entry", ie_flag, 1'b0);
        wait_for(1'b1, seen);
        chk("R6 jump pulse seen", seen, 1'b1);
        chk("R11 busy low at jump", busy, 1'b0);
        chk("R6/R9/R10 target offset", tgt_off, off_of(ev));
        chk("R6/R9/R10 target segment", tgt_seg, seg_of(ev));
        chk("R5 final stack pointer", tgt_sp, sp - 16'd6);
        chk("R7 target flags", tgt_flags, BASE_FLAGS);
        chk("R5 push 1 address", wlog_a[wb % 64], sp - 16'd2);
        chk("R5 push 1 flags (bit 9 = enable)", wlog_d[wb % 64], pushed);
        chk("R5 push 2 address", wlog_a[(wb + 1) % 64], sp - 16'd4);
        chk("R5 push 2 segment", wlog_d[(wb + 1) % 64], seg);
        chk("R5 push 3 address", wlog_a[(wb + 2) % 64], sp - 16'd6);
        chk("R5 push 3 offset", wlog_d[(wb + 2) % 64], off);
        chk("R4/R8/R10 acknowledge count", n_ack - ab, (kind == 3'd0) ? 1 : 0);
    endtask

    task automatic do_ret(input logic [15:0] sp, input logic [15:0] off,
                          input logic [15:0] pushed);
        bit seen;
        @(negedge clk);
        sp_in = sp; ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        wait_for(1'b0, seen);
        chk("R12 resume pulse seen", seen, 1'b1);
        chk("R12 resume offset", tgt_off, off);
        chk("R12 resume segment", tgt_seg, off ^ 16'h5A5A);
        chk("R12 resume flags", tgt_flags, pushed);
        chk("R12 resume stack pointer", tgt_sp, sp + 16'd6);
        chk("R12 enable restored", ie_flag, pushed[9]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<150000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] pushed;
        int m0, a0, j0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy after reset", busy, 1'b0);
        chk("R1 enable after reset", ie_flag, 1'b0);
        chk("R1 jump/resume after reset", {jmp_vld, rsm_vld}, 2'b00);
        chk("R1 ack/mem after reset", {ack_req, mem_req}, 2'b00);

        // table walk: each entry followed by a return
        for (int i = 0; i < 8; i++) begin
            do_entry(VTAB[i][43:41], VTAB[i][40], VTAB[i][39:32],
                     VTAB[i][31:16], VTAB[i][15:0], pushed);
            do_ret(VTAB[i][31:16] - 16'd6, VTAB[i][15:0], pushed);
        end

        // R3: maskable request with the flag clear is ignored
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m0 = n_mreq; a0 = n_ack;
        irq_req = 1'b1; ack_vec = 8'h21;
        repeat (5) @(negedge clk);
        chk("R3 busy stays low", busy, 1'b0);
        irq_req = 1'b0;
        @(negedge clk);
        chk("R3 no memory access", n_mreq - m0, 0);
        chk("R3 no acknowledge", n_ack - a0, 0);

        // R2: set then clear with a request in the same cycle
        flag_set = 1'b1;
        @(negedge clk);
        flag_set = 1'b0;
        chk("R2 set takes effect", ie_flag, 1'b1);
        flag_clr = 1'b1; irq_req = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0; irq_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 same-cycle clear blocks request", busy, 1'b0);
        chk("R2 flag cleared", ie_flag, 1'b0);
        flag_set = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        {flag_set, flag_clr} = '0;
        chk("R2 clear wins over set", ie_flag, 1'b0);

        // R11: requests raised while busy are dropped
        j0 = n_jmp;
        a0 = n_ack;
        cur_off = 16'h3333; cur_seg = 16'h3333 ^ 16'h5A5A; sp_in = 16'hFFF8;
        nmi_req = 1'b1;
        @(negedge clk);
        nmi_req = 1'b1; irq_req = 1'b1; sw_req = 1'b1; flag_set = 1'b1;
        repeat (3) @(negedge clk);
        {nmi_req, irq_req, sw_req, flag_set} = '0;
        repeat (30) @(negedge clk);
        chk("R11 single jump for overlapping requests", n_jmp - j0, 1);
        chk("R11 idle after drop", busy, 1'b0);
        chk("R11 flag set while busy dropped", ie_flag, 1'b0);
        chk("R8 vector 2 target offset", tgt_off, off_of(8'h02));
        chk("R8 no acknowledge", n_ack - a0, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule